// File: doc/BRIEF.md
# Polyphase Interpolate-by-Two Halfband Filter

This block doubles the sample rate of a signed real stream. The zero-stuffed transversal filter is split into two polyphase branches. The even branch multiplies the history by the coefficients with even index. The odd branch does the same with the coefficients with odd index. Both branches work on the same captured samples at the input rate. Each branch result is doubled to restore the level lost by zero insertion, then rounded and saturated back to the sample width.

A small controller with four named states sets the timing. `ST_WAIT` idles until a sync pulse arrives. `ST_CAP` captures a sample and emits the odd-branch result. `ST_EVEN` emits the even-branch result without capturing. `ST_DUAL` captures on every clock and drives both branches onto separate ports.

The transitions are as follows. With single-port mode selected, a sync pulse seen in any state leads to `ST_CAP`. Without sync, `ST_WAIT` stays in `ST_WAIT`, `ST_CAP` goes to `ST_EVEN`, `ST_EVEN` goes to `ST_CAP`, and `ST_DUAL` falls back to `ST_WAIT`. With dual-port mode selected, every state goes to `ST_DUAL`. In single-port mode the clock runs at the output rate and port A carries the interleaved stream. In dual-port mode the clock runs at the input rate, and the two ports are interleaved outside the block with port B first.

Top module: `interp2_halfband`

## Requirements
- R1: While rst_n is low, out_valid, out_a and out_b are 0, the state is ST_WAIT and the sample history is cleared to zero. After release, outputs are computed as if every earlier sample were zero.
- R2: Coefficient j sits at bits [16j+15:16j] of the COEFS parameter. With x[m-k] the sample captured k captures before the latest one, the even branch sums C[2k]·x[m-k] for k=0..3 and the odd branch sums C[2k+1]·x[m-k] for k=0..2.
- R3: A branch sum S (coefficients with 15 fraction bits) is emitted as floor((S + 8192) / 16384), which is twice the sum, rounded. The result is then saturated to the range -32768..32767.
- R4: With mode_single=1, no sample is captured until sync is sampled high at a rising edge. The first capture is at the next edge, and captures then follow on every second edge. Sync sampled high in any state makes the next edge a capture edge.
- R5: In single-port mode, a capture edge loads out_a with the odd-branch result of the history before the capture. The following edge loads out_a with the even-branch result of the history that includes the new sample. Port A therefore carries odd, even, odd, even and so on at twice the input rate.
- R6: With mode_single=0, every edge captures din. On that edge out_b takes the odd-branch result of the history before the capture and out_a takes the even-branch result including the new sample. Port B is the earlier sample in time, and sync has no effect.
- R7: out_valid is 1 after every edge taken in ST_CAP, ST_EVEN or ST_DUAL, and 0 after every edge taken in ST_WAIT.
- R8: Going from dual-port to single-port mode without sync returns to ST_WAIT, where nothing is captured or emitted. out_b holds its value whenever the state is not ST_DUAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: output rate in single-port mode, input rate in dual-port mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_single | input | 1 | 1 = interleave onto port A; 0 = separate ports A and B |
| sync | input | 1 | Capture phasing pulse, used only in single-port mode |
| din | input | 16 | Signed input sample |
| out_a | output | 16 | Interleaved stream (single) or even-branch stream (dual) |
| out_b | output | 16 | Odd-branch stream in dual-port mode |
| out_valid | output | 1 | High while the outputs carry a newly emitted sample |

## Verification
The assertions check the state sequence on every cycle. They cover entry to ST_CAP after sync, the CAP/EVEN alternation, the forced move to ST_DUAL, valid against the state, and the history and port B staying still outside capture and dual states. The arithmetic content of every sample can only be shown by the bench scenarios. These cover the branch sums with an asymmetric coefficient set, doubling and rounding, saturation at both rails, the odd-before-even ordering on one port and B-before-A on two, re-phasing by sync in the middle of a run, and mode switches.

// File: rtl/interp2_pkg.sv
package interp2_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_CAP  = 2'd1,
        ST_EVEN = 2'd2,
        ST_DUAL = 2'd3
    } i2_state_e;

endpackage

// File: rtl/interp2_ctrl.sv
module interp2_ctrl
    import interp2_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_single,
    input  logic      sync,
    output i2_state_e state,
    output logic      shift_en,
    output logic      load_a,
    output logic      load_b,
    output logic      a_even,
    output logic      even_next
);

    i2_state_e state_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_n;
    end

    // Next state: dual mode dominates, sync re-phases single mode
    always_comb begin
        state_n = state;
        if (!mode_single) begin
            state_n = ST_DUAL;
        end else if (sync) begin
            state_n = ST_CAP;
        end else begin
            unique case (state)
                ST_WAIT: state_n = ST_WAIT;
                ST_CAP:  state_n = ST_EVEN;
                ST_EVEN: state_n = ST_CAP;
                ST_DUAL: state_n = ST_WAIT;
            endcase
        end
    end

    // Per-state actions for the current edge
    always_comb begin
        shift_en  = 1'b0;
        load_a    = 1'b0;
        load_b    = 1'b0;
        a_even    = 1'b0;
        even_next = 1'b0;
        unique case (state)
            ST_WAIT: ;
            ST_CAP: begin
                shift_en = 1'b1;
                load_a   = 1'b1;
            end
            ST_EVEN: begin
                load_a = 1'b1;
                a_even = 1'b1;
            end
            ST_DUAL: begin
                shift_en  = 1'b1;
                load_a    = 1'b1;
                load_b    = 1'b1;
                a_even    = 1'b1;
                even_next = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/interp2_branch.sv
module interp2_branch #(
    parameter int              DW    = 16,
    parameter int              CW    = 16,
    parameter int              NT    = 7,
    parameter int              PHASE = 0,
    parameter int              NB    = 4,
    parameter int              AW    = 37,
    parameter logic [NT*CW-1:0] COEFS = '0
) (
    input  logic [NB*DW-1:0]     line,
    output logic signed [AW-1:0] acc
);

    logic signed [AW-1:0] prod [NB];

    for (genvar k = 0; k < NB; k++) begin : g_tap
        localparam logic signed [CW-1:0] CK = COEFS[(2*k+PHASE)*CW +: CW];
        assign prod[k] = AW'($signed(line[k*DW +: DW])) * AW'(CK);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NB; k++) acc = acc + prod[k];
    end

endmodule

// File: rtl/interp2_scale.sv
module interp2_scale #(
    parameter int AW   = 37,
    parameter int DW   = 16,
    parameter int FRAC = 15
) (
    input  logic signed [AW-1:0] acc,
    output logic signed [DW-1:0] y
);

    // Doubling folds into a shift one short of the fraction width
    localparam int                 SH   = FRAC - 1;
    localparam logic signed [AW:0] RND  = (AW+1)'(1) <<< (SH - 1);
    localparam logic signed [AW:0] MAXV = (AW+1)'((2**(DW-1)) - 1);
    localparam logic signed [AW:0] MINV = -MAXV - (AW+1)'(1);

    logic signed [AW:0] biased;
    logic signed [AW:0] shf;

    always_comb begin
        biased = {acc[AW-1], acc} + RND;
        shf    = biased >>> SH;
        if (shf > MAXV)      y = {1'b0, {(DW-1){1'b1}}};
        else if (shf < MINV) y = {1'b1, {(DW-1){1'b0}}};
        else                 y = shf[DW-1:0];
    end

endmodule

// File: rtl/interp2_halfband.sv
module interp2_halfband
    import interp2_pkg::*;
#(
    parameter int               DW    = 16,
    parameter int               CW    = 16,
    parameter int               NT    = 7,
    parameter int               FRAC  = 15,
    parameter logic [NT*CW-1:0] COEFS = {-16'sd1024, 16'sd0, 16'sd9216, 16'sd16384,
                                          16'sd9216, 16'sd0, -16'sd1024}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_single,
    input  logic          sync,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] out_a,
    output logic [DW-1:0] out_b,
    output logic          out_valid
);

    localparam int NE = (NT + 1) / 2;
    localparam int NO = NT / 2;
    localparam int AW = DW + CW + $clog2(NT) + 2;

    i2_state_e state;
    logic      shift_en, load_a, load_b, a_even, even_next;

    logic [NE*DW-1:0]     dline_q;
    logic [NE*DW-1:0]     dline_n;
    logic [NE*DW-1:0]     even_in;
    logic signed [AW-1:0] acc_even, acc_odd;
    logic signed [DW-1:0] y_even, y_odd;

    interp2_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_single(mode_single),
        .sync       (sync),
        .state      (state),
        .shift_en   (shift_en),
        .load_a     (load_a),
        .load_b     (load_b),
        .a_even     (a_even),
        .even_next  (even_next)
    );

    // Newest sample occupies the lowest slot
    assign dline_n = {dline_q[(NE-1)*DW-1:0], din};
    assign even_in = even_next ? dline_n : dline_q;

    interp2_branch #(
        .DW(DW), .CW(CW), .NT(NT), .PHASE(0), .NB(NE), .AW(AW), .COEFS(COEFS)
    ) u_even (
        .line(even_in),
        .acc (acc_even)
    );

    interp2_branch #(
        .DW(DW), .CW(CW), .NT(NT), .PHASE(1), .NB(NO), .AW(AW), .COEFS(COEFS)
    ) u_odd (
        .line(dline_q[NO*DW-1:0]),
        .acc (acc_odd)
    );

    interp2_scale #(.AW(AW), .DW(DW), .FRAC(FRAC)) u_scl_even (
        .acc(acc_even),
        .y  (y_even)
    );

    interp2_scale #(.AW(AW), .DW(DW), .FRAC(FRAC)) u_scl_odd (
        .acc(acc_odd),
        .y  (y_odd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dline_q   <= '0;
            out_a     <= '0;
            out_b     <= '0;
            out_valid <= 1'b0;
        end else begin
            if (shift_en) dline_q <= dline_n;
            if (load_a)   out_a   <= a_even ? y_even : y_odd;
            if (load_b)   out_b   <= y_odd;
            out_valid <= load_a;
        end
    end

endmodule

// File: rtl/interp2_halfband_chk.sv
module interp2_halfband_chk
    import interp2_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_single,
    input logic          sync,
    input i2_state_e     state,
    input logic          out_valid,
    input logic [DW-1:0] out_b,
    input logic [DW-1:0] head
);

    a_r4_sync_to_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_single && sync) |=> (state == ST_CAP));

    a_r5_capture_then_even: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_single && !sync && state == ST_CAP) |=> (state == ST_EVEN));

    a_r5_even_then_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_single && state == ST_EVEN) |=> (state == ST_CAP));

    a_r6_dual_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_single |=> (state == ST_DUAL));

    a_r7_valid_active: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WAIT) |=> out_valid);

    a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> !out_valid);

    a_r8_dual_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_single && !sync && state == ST_DUAL) |=> (state == ST_WAIT));

    a_r8_portb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DUAL) |=> $stable(out_b));

    a_r4_history_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT || state == ST_EVEN) |=> $stable(head));

endmodule

bind interp2_halfband interp2_halfband_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_single(mode_single),
    .sync       (sync),
    .state      (state),
    .out_valid  (out_valid),
    .out_b      (out_b),
    .head       (dline_q[DW-1:0])
);

// File: tb/interp2_halfband_bench.sv
`timescale 1ns/1ps
module interp2_halfband_bench;

    logic        clk = 1'b0;
    logic        rst_n, mode_single, sync;
    logic [15:0] din;
    logic [15:0] out_a, out_b;
    logic        out_valid;

    always #4 clk = ~clk;

    // Asymmetric set so that a reversed tap order is visible
    localparam logic [111:0] TB_COEFS = {16'sd1000, -16'sd2000, 16'sd9000, 16'sd16384,
                                         16'sd12000, -16'sd5000, 16'sd3000};
    int cf [7] = '{3000, -5000, 12000, 16384, 9000, -2000, 1000};

    interp2_halfband #(.COEFS(TB_COEFS)) u_interp2_halfband (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_single(mode_single),
        .sync       (sync),
        .din        (din),
        .out_a      (out_a),
        .out_b      (out_b),
        .out_valid  (out_valid)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    bit     finished = 0;
    longint hist [4];
    int     mst;
    int     ea, eb;
    bit     ev;
    string  ptag;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rnd(longint a);
        longint r;
        r = (a + 64'sd8192) >>> 14;
        if (r > 32767)  return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    function automatic longint evs();
        longint s = 0;
        for (int k = 0; k < 4; k++) s += longint'(cf[2*k]) * hist[k];
        return s;
    endfunction

    function automatic longint ods();
        longint s = 0;
        for (int k = 0; k < 3; k++) s += longint'(cf[2*k+1]) * hist[k];
        return s;
    endfunction

    task automatic push(int d);
        logic [15:0] v;
        v = 16'(d);
        for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'($signed(v));
    endtask

    // One clock: drive at a falling edge, predict, check at the next falling edge
    task automatic cyc(int d, bit s, bit m);
        int prev;
        din = 16'(d);
        sync = s;
        mode_single = m;
        prev = mst;
        ev = (mst != 0);
        case (mst)
            1: begin ea = rnd(ods()); push(d); end
            2: ea = rnd(evs());
            3: begin eb = rnd(ods()); push(d); ea = rnd(evs()); end
            default: ;
        endcase
        if (!m)     mst = 3;
        else if (s) mst = 1;
        else case (mst)
            0: mst = 0;
            1: mst = 2;
            2: mst = 1;
            default: mst = 0;
        endcase
        @(posedge clk);
        @(negedge clk);
        check("R7 out_valid", int'(out_valid), int'(ev));
        check(prev == 3 ? "R6 out_a" : {ptag, " out_a"}, int'($signed(out_a)), ea);
        check(prev == 3 ? "R6 out_b" : "R8 out_b held", int'($signed(out_b)), eb);
    endtask

    function automatic int prng(int i);
        return ((i * 40503 + 17) & 16'hFFFF);
    endfunction

    initial begin
        rst_n = 1'b0;
        mode_single = 1'b1;
        sync = 1'b0;
        din = '0;
        mst = 0;
        ea = 0;
        eb = 0;
        ptag = "R1";
        for (int k = 0; k < 4; k++) hist[k] = 0;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_a in reset", int'(out_a), 0);
        check("R1 out_b in reset", int'(out_b), 0);
        rst_n = 1'b1;

        // No sync yet: nothing emitted
        ptag = "R4";
        for (int i = 0; i < 4; i++) cyc(i * 1000 + 5, 1'b0, 1'b1);
        cyc(777, 1'b1, 1'b1);

        // Impulse: exposes each coefficient and the zero history after reset
        ptag = "R2";
        for (int i = 0; i < 12; i++) cyc((i == 2 || i == 3) ? 20000 : 0, 1'b0, 1'b1);

        ptag = "R5";
        for (int i = 0; i < 24; i++) cyc(i * 1500 - 30000, 1'b0, 1'b1);

        // Both rails
        ptag = "R3";
        for (int i = 0; i < 10; i++) cyc(32767, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) cyc(-32768, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) cyc((i % 4 < 2) ? 32767 : -32768, 1'b0, 1'b1);

        // Re-phasing by sync in either phase, including back to back
        ptag = "R4";
        for (int i = 0; i < 30; i++)
            cyc(prng(i), (i == 7 || i == 8 || i == 15 || i == 22), 1'b1);

        // Dual-port mode, sync toggling without effect
        ptag = "R6";
        for (int i = 0; i < 30; i++) cyc(prng(i + 100), (i % 3 == 0), 1'b0);
        for (int i = 0; i < 8; i++) cyc(32767, 1'b1, 1'b0);

        // Back to single without sync: idle, port B frozen
        ptag = "R8";
        for (int i = 0; i < 6; i++) cyc(prng(i + 200), 1'b0, 1'b1);
        cyc(prng(300), 1'b1, 1'b1);
        ptag = "R5";
        for (int i = 0; i < 20; i++) cyc(prng(i + 400), 1'b0, 1'b1);

        // Leave single mode straight from a capture edge
        ptag = "R6";
        for (int i = 0; i < 6; i++) cyc(prng(i + 500), 1'b0, 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule